// File: doc/BRIEF.md
# Split-Byte General Register File

This block holds eight 16-bit general-purpose registers behind one write port and two independent read ports. Registers 0 to 3 (accumulator, base, count and data) can be accessed either as a whole word or as either of their two byte halves. Registers 4 to 7 (frame pointer, source index, destination index and stack pointer) can only be accessed as whole words. A byte write merges the new byte into the addressed half and keeps the other half. A byte read returns the chosen half, zero-extended to 16 bits.

A byte request that names one of the word-only registers is illegal and raises an error flag. An illegal write is dropped and leaves every register unchanged. Reads are combinational. A write takes effect at the next rising clock edge, so a read of the same register in the same cycle still returns the value from before the write.

The write side follows a valid/ready handshake. `wr_ready` is held high at all times, so the block never applies back-pressure. A write is accepted in every cycle in which `wr_valid` is high. The read ports are plain combinational lookups and have no handshake.

Top module: `byte_lane_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all eight registers to 0000h. Any write requested while rst is high is ignored.
- R2: A word write (wr_bsel=0) with wr_valid high replaces the whole register at wr_idx from the next rising edge. A read of that register in the same cycle returns the old value.
- R3: A low-byte write (wr_bsel=1, wr_hi=0) to index 0..3 puts wr_data[7:0] into bits 7:0 and keeps bits 15:8. Example: 76E9h followed by a low-byte write of 0Ah reads back as 760Ah.
- R4: A high-byte write (wr_bsel=1, wr_hi=1) to index 0..3 puts wr_data[7:0] into bits 15:8 and keeps bits 7:0.
- R5: A byte read (rdN_bsel=1) of index 0..3 returns bits 15:8 when rdN_hi=1 and bits 7:0 when rdN_hi=0, with the upper 8 bits of the output at zero. Example: with 76E9h stored, the high byte reads 0076h and the low byte reads 00E9h.
- R6: A byte request to index 4..7 is illegal. For a write, wr_err is high in that cycle whenever wr_valid is high, and no register changes. For a read, rdN_err is high and rdN_data is 0000h.
- R7: A word read (rdN_bsel=0) of any index returns the full 16-bit register. The two read ports operate independently of each other.
- R8: wr_ready is always 1. In a cycle with wr_valid low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted (constant 1) |
| wr_idx | input | 3 | Write register index |
| wr_bsel | input | 1 | 1 = byte write, 0 = word write |
| wr_hi | input | 1 | Byte write targets bits 15:8 when 1 |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| wr_err | output | 1 | Illegal byte write flagged |
| rd0_idx | input | 3 | Read port 0 index |
| rd0_bsel | input | 1 | Read port 0 byte mode |
| rd0_hi | input | 1 | Read port 0 high-byte select |
| rd0_data | output | 16 | Read port 0 data |
| rd0_err | output | 1 | Read port 0 illegal byte access |
| rd1_idx | input | 3 | Read port 1 index |
| rd1_bsel | input | 1 | Read port 1 byte mode |
| rd1_hi | input | 1 | Read port 1 high-byte select |
| rd1_data | output | 16 | Read port 1 data |
| rd1_err | output | 1 | Read port 1 illegal byte access |

## Verification
Read data, both read error flags and wr_err all depend on the current inputs in the same cycle, with zero cycles of latency. A write shows up on the read ports one rising edge after it is presented. The bench applies inputs at the falling edge and samples the outputs 1 ns later, while the registers still hold their pre-write contents. It checks those samples against a reference model that has not yet taken the write. The model takes the write only after the following rising edge, so a same-cycle read is always compared against the old value, and the next cycle's read is compared against the merged value.

// File: rtl/blr_pkg.sv
package blr_pkg;
  localparam int DATA_W    = 16;
  localparam int NUM_REGS  = 8;
  localparam int NUM_SPLIT = 4;

  typedef enum logic {ACC_WORD = 1'b0, ACC_BYTE = 1'b1} acc_size_e;
endpackage

// File: rtl/blr_access_chk.sv
module blr_access_chk #(
  parameter int IW     = 3,
  parameter int NSPLIT = 4
) (
  input  logic [IW-1:0] idx,
  input  logic          bsel,
  output logic          legal
);
  // byte granularity exists only on the low-numbered registers
  always_comb begin
    legal = 1'b1;
    if (blr_pkg::acc_size_e'(bsel) == blr_pkg::ACC_BYTE && idx >= IW'(NSPLIT))
      legal = 1'b0;
  end
endmodule

// File: rtl/blr_wr_merge.sv
module blr_wr_merge #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] din,
  input  logic          bsel,
  input  logic          hi,
  output logic [DW-1:0] merged
);
  localparam int BW = DW / 2;

  always_comb begin
    if (blr_pkg::acc_size_e'(bsel) == blr_pkg::ACC_WORD)
      merged = din;
    else if (hi)
      merged = {din[BW-1:0], old_val[BW-1:0]};
    else
      merged = {old_val[DW-1:BW], din[BW-1:0]};
  end
endmodule

// File: rtl/blr_rd_port.sv
module blr_rd_port #(
  parameter int DW     = 16,
  parameter int NREG   = 8,
  parameter int NSPLIT = 4,
  parameter int IW     = 3
) (
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [IW-1:0]           idx,
  input  logic                    bsel,
  input  logic                    hi,
  output logic [DW-1:0]           dout,
  output logic                    err
);
  localparam int BW = DW / 2;

  logic          legal;
  logic [DW-1:0] word;

  blr_access_chk #(.IW(IW), .NSPLIT(NSPLIT)) u_acc (
    .idx(idx), .bsel(bsel), .legal(legal)
  );

  assign word = regs[idx];
  assign err  = ~legal;

  always_comb begin
    if (!legal)
      dout = '0;
    else if (blr_pkg::acc_size_e'(bsel) == blr_pkg::ACC_WORD)
      dout = word;
    else if (hi)
      dout = {{BW{1'b0}}, word[DW-1:BW]};
    else
      dout = {{BW{1'b0}}, word[BW-1:0]};
  end
endmodule

// File: rtl/byte_lane_regfile.sv
module byte_lane_regfile #(
  parameter int DW     = blr_pkg::DATA_W,
  parameter int NREG   = blr_pkg::NUM_REGS,
  parameter int NSPLIT = blr_pkg::NUM_SPLIT,
  localparam int IW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_bsel,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  output logic          wr_err,
  input  logic [IW-1:0] rd0_idx,
  input  logic          rd0_bsel,
  input  logic          rd0_hi,
  output logic [DW-1:0] rd0_data,
  output logic          rd0_err,
  input  logic [IW-1:0] rd1_idx,
  input  logic          rd1_bsel,
  input  logic          rd1_hi,
  output logic [DW-1:0] rd1_data,
  output logic          rd1_err
);
  localparam int NRD = 2;

  logic [NREG-1:0][DW-1:0] regs_q;
  logic                    wr_legal;
  logic                    wr_fire;
  logic [DW-1:0]           wr_merged;

  blr_access_chk #(.IW(IW), .NSPLIT(NSPLIT)) u_wacc (
    .idx(wr_idx), .bsel(wr_bsel), .legal(wr_legal)
  );

  blr_wr_merge #(.DW(DW)) u_merge (
    .old_val(regs_q[wr_idx]), .din(wr_data), .bsel(wr_bsel), .hi(wr_hi),
    .merged(wr_merged)
  );

  assign wr_ready = 1'b1;
  assign wr_err   = wr_valid & ~wr_legal;
  assign wr_fire  = wr_valid & wr_ready & wr_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else if (wr_fire) begin
      regs_q[wr_idx] <= wr_merged;
    end
  end

  logic [NRD-1:0][IW-1:0] rp_idx;
  logic [NRD-1:0]         rp_bsel, rp_hi, rp_err;
  logic [NRD-1:0][DW-1:0] rp_data;

  assign rp_idx  = {rd1_idx, rd0_idx};
  assign rp_bsel = {rd1_bsel, rd0_bsel};
  assign rp_hi   = {rd1_hi, rd0_hi};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    blr_rd_port #(.DW(DW), .NREG(NREG), .NSPLIT(NSPLIT), .IW(IW)) u_rd (
      .regs(regs_q), .idx(rp_idx[p]), .bsel(rp_bsel[p]), .hi(rp_hi[p]),
      .dout(rp_data[p]), .err(rp_err[p])
    );
  end

  assign rd0_data = rp_data[0];
  assign rd1_data = rp_data[1];
  assign rd0_err  = rp_err[0];
  assign rd1_err  = rp_err[1];
endmodule

// File: rtl/byte_lane_regfile_chk.sv
module byte_lane_regfile_chk #(
  parameter int DW     = 16,
  parameter int NREG   = 8,
  parameter int NSPLIT = 4,
  parameter int IW     = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic [IW-1:0]           wr_idx,
  input logic                    wr_bsel,
  input logic                    wr_hi,
  input logic [DW-1:0]           wr_data,
  input logic                    wr_err,
  input logic [NREG-1:0][DW-1:0] regs_q
);
  localparam int BW = DW / 2;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (regs_q == '0));

  a_r3_low_keeps_high: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_bsel && !wr_hi && wr_idx < IW'(NSPLIT)) |=>
      (regs_q[$past(wr_idx)][DW-1:BW] == $past(regs_q[wr_idx][DW-1:BW]) &&
       regs_q[$past(wr_idx)][BW-1:0] == $past(wr_data[BW-1:0])));

  a_r4_high_keeps_low: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_bsel && wr_hi && wr_idx < IW'(NSPLIT)) |=>
      (regs_q[$past(wr_idx)][BW-1:0] == $past(regs_q[wr_idx][BW-1:0]) &&
       regs_q[$past(wr_idx)][DW-1:BW] == $past(wr_data[BW-1:0])));

  a_r6_err_flagged: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_bsel && wr_idx >= IW'(NSPLIT)) |-> wr_err);

  a_r6_err_no_change: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> (regs_q == $past(regs_q)));

  a_r8_always_ready: assert property (@(posedge clk) disable iff (rst)
    wr_ready);

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> (regs_q == $past(regs_q)));
endmodule

bind byte_lane_regfile byte_lane_regfile_chk #(
  .DW(DW), .NREG(NREG), .NSPLIT(NSPLIT), .IW(IW)
) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_idx(wr_idx), .wr_bsel(wr_bsel), .wr_hi(wr_hi), .wr_data(wr_data),
  .wr_err(wr_err), .regs_q(regs_q)
);

// File: tb/sim_byte_lane_regfile.sv
module sim_byte_lane_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0, wr_bsel = 1'b0, wr_hi = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        wr_ready, wr_err;
  logic [2:0]  rd0_idx = '0, rd1_idx = '0;
  logic        rd0_bsel = 1'b0, rd0_hi = 1'b0, rd1_bsel = 1'b0, rd1_hi = 1'b0;
  logic [15:0] rd0_data, rd1_data;
  logic        rd0_err, rd1_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] mdl [8];

  always #2 clk = ~clk;

  byte_lane_regfile u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_bsel(wr_bsel), .wr_hi(wr_hi), .wr_data(wr_data),
    .wr_err(wr_err),
    .rd0_idx(rd0_idx), .rd0_bsel(rd0_bsel), .rd0_hi(rd0_hi),
    .rd0_data(rd0_data), .rd0_err(rd0_err),
    .rd1_idx(rd1_idx), .rd1_bsel(rd1_bsel), .rd1_hi(rd1_hi),
    .rd1_data(rd1_data), .rd1_err(rd1_err)
  );

  function automatic logic illegal(logic [2:0] i, logic b);
    return b && (i >= 3'd4);
  endfunction

  function automatic logic [15:0] exp_rd(logic [2:0] i, logic b, logic h);
    if (illegal(i, b)) return 16'h0000;
    if (!b) return mdl[i];
    return h ? {8'h00, mdl[i][15:8]} : {8'h00, mdl[i][7:0]};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic wv, logic [2:0] wi, logic wb, logic wh, logic [15:0] wd,
                      logic [2:0] r0i, logic r0b, logic r0h,
                      logic [2:0] r1i, logic r1b, logic r1h, string tag);
    @(negedge clk);
    wr_valid = wv; wr_idx = wi; wr_bsel = wb; wr_hi = wh; wr_data = wd;
    rd0_idx = r0i; rd0_bsel = r0b; rd0_hi = r0h;
    rd1_idx = r1i; rd1_bsel = r1b; rd1_hi = r1h;
    #1;
    // same-cycle reads see pre-write contents (R2)
    check({tag, " port0"}, rd0_data, exp_rd(r0i, r0b, r0h));
    check({tag, " port1"}, rd1_data, exp_rd(r1i, r1b, r1h));
    check("R6 rd0_err", {15'd0, rd0_err}, {15'd0, illegal(r0i, r0b)});
    check("R6 rd1_err", {15'd0, rd1_err}, {15'd0, illegal(r1i, r1b)});
    check("R6 wr_err", {15'd0, wr_err}, {15'd0, wv && illegal(wi, wb)});
    check("R8 wr_ready", {15'd0, wr_ready}, 16'd1);
    @(posedge clk);
    if (wv && !illegal(wi, wb)) begin
      if (!wb) mdl[wi] = wd;
      else if (wh) mdl[wi][15:8] = wd[7:0];
      else mdl[wi][7:0] = wd[7:0];
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int k = 0; k < 8; k++) mdl[k] = 16'h0000;
    // R1: writes under reset are ignored
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_idx = 3'(k); wr_bsel = 1'b0; wr_data = 16'hBEEF;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rd0_idx = 3'(k); rd0_bsel = 1'b0;
      #1;
      check("R1 reset value", rd0_data, 16'h0000);
    end

    // R2 word write, then R5 byte reads of it
    step(1, 3'd0, 0, 0, 16'h76E9, 3'd0, 0, 0, 3'd0, 0, 0, "R2 old value");
    step(0, 3'd0, 0, 0, 16'h0000, 3'd0, 1, 1, 3'd0, 1, 0, "R5 halves");
    check("R5 high byte", rd0_data, 16'h0076);
    check("R5 low byte", rd1_data, 16'h00E9);
    // R3 low byte merge
    step(1, 3'd0, 1, 0, 16'hFF0A, 3'd0, 0, 0, 3'd1, 0, 0, "R3 pre");
    step(0, 3'd0, 0, 0, 16'h0000, 3'd0, 0, 0, 3'd0, 1, 1, "R3 merge");
    check("R3 word after low write", rd0_data, 16'h760A);
    // R4 high byte merge on register 3
    step(1, 3'd3, 0, 0, 16'h1234, 3'd3, 0, 0, 3'd3, 0, 0, "R2 word");
    step(1, 3'd3, 1, 1, 16'h00AB, 3'd3, 0, 0, 3'd3, 1, 0, "R4 pre");
    step(0, 3'd3, 0, 0, 16'h0000, 3'd3, 0, 0, 3'd3, 1, 1, "R4 merge");
    check("R4 word after high write", rd0_data, 16'hAB34);
    // R6 illegal byte write to word-only register keeps it
    step(1, 3'd5, 0, 0, 16'hC0DE, 3'd5, 0, 0, 3'd5, 1, 0, "R7 word-only");
    step(1, 3'd5, 1, 1, 16'h0099, 3'd5, 1, 1, 3'd7, 1, 0, "R6 illegal");
    step(0, 3'd5, 0, 0, 16'h0000, 3'd5, 0, 0, 3'd4, 0, 0, "R6 unchanged");
    check("R6 reg5 kept", rd0_data, 16'hC0DE);
    // R8 idle cycle with data on the bus
    step(0, 3'd1, 0, 0, 16'h5555, 3'd1, 0, 0, 3'd1, 0, 0, "R8 idle");
    step(0, 3'd1, 0, 0, 16'h0000, 3'd1, 0, 0, 3'd0, 0, 0, "R8 after idle");
    check("R8 reg1 unchanged", rd0_data, 16'h0000);

    // random mix, R7 independent ports
    for (int n = 0; n < 800; n++) begin
      step(1'($urandom % 4 != 0), 3'($urandom), 1'($urandom), 1'($urandom),
           16'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
           3'($urandom), 1'($urandom), 1'($urandom), "R5/R7 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule